// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block builds the byte a host sees when it reads a flash device while an embedded program or erase is running, while an erase is suspended, or after such an operation has finished. An external controller tells it the current operation mode, the byte being programmed, the blocks chosen for erase, which of those are write-protected, whether the erase-collection window is still open, and when a failure happened. On each single-cycle read strobe the block updates its two toggle flip-flops. Its output byte always holds a polling bit, two toggle bits, a sticky error bit and an erase-timer bit, or the raw array byte where the host should see plain data.

The read address is decoded into one of seven blocks from its five top bits. One toggle bit (bit 6) shows that an operation is still busy. The other (bit 2) toggles only on reads inside a block chosen for erase. A host can therefore walk the address space and find which block an erase or a suspend is acting on.

Mode codes on the `mode` input: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program while erase is suspended.

Top module: `pesr_top`

## Requirements
- R1: In mode 1 or 4, bit 7 of `rd_data` is the inverse of `prog_data[7]`. After the mode returns from 1 to 0, bit 7 holds the true value of the last programmed bit 7 until `rd_reset`.
- R2: In mode 2, bit 7 reads 0. After the mode returns from 2 to 0 (no protect abort), bit 7 reads 1 until `rd_reset`.
- R3: In modes 1, 2 and 4, bit 6 inverts on every read strobe. Once the operation has finished and the mode is 0, bit 6 no longer changes.
- R4: Blocks are decoded from address bits [17:13]: 0x00-0x07 block 0, 0x08-0x0F block 1, 0x10-0x17 block 2, 0x18-0x1B block 3, 0x1C block 4, 0x1D block 5, 0x1E-0x1F block 6. In mode 2, bit 2 inverts on each read strobe at an address in a block whose `erase_sel` bit is set, and reads 1 elsewhere.
- R5: Bit 2 reads 1 in modes 1 and 4, and after an erase has completed.
- R6: In mode 3, a read inside a block selected for erase returns 1 on bit 7 and on bit 6, and bit 2 inverts on each strobe there. A read in any other block returns `array_data`.
- R7: Bit 5 is set by a `fail_in` pulse, or when a program starts (mode enters 1 or 4) with a 1 in `prog_data` at a position where `cell_old` holds 0. It stays set until `rd_reset`.
- R8: In mode 2, bit 3 reads 0 while `erase_window` is 1 and reads 1 once it is 0.
- R9: Bits 4, 1 and 0 read 0 in every status byte.
- R10: If the erase starts (mode 2 with `erase_window` 0) and every selected block is protected in `prot_sel`, bit 7 reads 0 and bit 6 toggles for ABORT_CYC cycles. After that, reads return `array_data` until a new operation starts.
- R11: After reset or `rd_reset`, and with no finished operation recorded, mode 0 returns `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operation mode code (0 to 4) |
| prog_data | input | 8 | Byte being programmed |
| cell_old | input | 8 | Current content of the cell being programmed |
| rd_addr | input | ADDR_W | Read address |
| rd_stb | input | 1 | Single-cycle read strobe |
| erase_sel | input | 7 | Blocks selected for erase, one bit per block |
| prot_sel | input | 7 | Blocks that are write-protected |
| fail_in | input | 1 | Program or erase failure pulse |
| rd_reset | input | 1 | Read/reset command, clears the error and the finished-operation record |
| erase_window | input | 1 | High while further erase blocks may still be added |
| array_data | input | 8 | Array byte at the read address |
| rd_data | output | 8 | Byte returned to the host |

## Verification
On every cycle, the checker holds the static relations between the mode and the status bits. It checks the inverted polling bit during a program, the forced bit 2 and the zero reserved bits, and the zero timer and polling bits while the erase window is open. It also checks that bit 6 inverts after each strobe in program mode, that the error bit stays set until a read/reset, and that bit 7 reads low during a protect abort. Only the bench scenarios can show the finished-operation record with its true polling bit and frozen toggle. The same holds for bit 2 toggling in exactly the selected blocks, for each erase subset and block, for the suspend pass-through, and for the return to array data once the abort count runs out.

// File: rtl/pesr_pkg.sv
package pesr_pkg;

    localparam int unsigned NUM_BLOCKS = 7;
    localparam int unsigned BLK_TOP_W  = 5;

    typedef enum logic [2:0] {
        MODE_IDLE      = 3'd0,
        MODE_PROG      = 3'd1,
        MODE_ERASE     = 3'd2,
        MODE_SUSP      = 3'd3,
        MODE_SUSP_PROG = 3'd4
    } pe_mode_e;

    typedef enum logic [1:0] {
        DONE_NONE  = 2'd0,
        DONE_PROG  = 2'd1,
        DONE_ERASE = 2'd2
    } done_e;

    typedef struct packed {
        logic       poll;     // bit 7
        logic       busy_tog; // bit 6
        logic       err;      // bit 5
        logic       rsv_hi;   // bit 4
        logic       timer;    // bit 3
        logic       blk_tog;  // bit 2
        logic [1:0] rsv_lo;   // bits 1..0
    } status_t;

    function automatic logic [2:0] block_of(input logic [BLK_TOP_W-1:0] top);
        logic [2:0] b;
        if (top < 5'h08)       b = 3'd0;
        else if (top < 5'h10)  b = 3'd1;
        else if (top < 5'h18)  b = 3'd2;
        else if (top < 5'h1C)  b = 3'd3;
        else if (top == 5'h1C) b = 3'd4;
        else if (top == 5'h1D) b = 3'd5;
        else                   b = 3'd6;
        return b;
    endfunction

    function automatic logic is_prog(input pe_mode_e m);
        return (m == MODE_PROG) || (m == MODE_SUSP_PROG);
    endfunction

endpackage

// File: rtl/pesr_block_map.sv
module pesr_block_map
    import pesr_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_BLOCKS-1:0] sel,
    output logic                  in_sel
);
    localparam int unsigned TOP_LSB = ADDR_W - BLK_TOP_W;

    logic [NUM_BLOCKS-1:0] hit;
    logic [2:0]            blk;

    assign blk = block_of(addr[ADDR_W-1:TOP_LSB]);

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_hit
        assign hit[i] = (blk == 3'(i));
    end

    assign in_sel = |(hit & sel);
endmodule

// File: rtl/pesr_toggle.sv
module pesr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic cond,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)              q <= 1'b0;
        else if (stb && cond) q <= ~q;
    end
endmodule

// File: rtl/pesr_err_track.sv
module pesr_err_track (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       fail_in,
    input  logic       prog_start,
    input  logic [7:0] new_byte,
    input  logic [7:0] old_byte,
    output logic       err
);
    logic raise_bit;

    // a 1 requested where the cell already holds 0 cannot be programmed
    assign raise_bit = |(new_byte & ~old_byte);

    always_ff @(posedge clk) begin
        if (rst || clr)
            err <= 1'b0;
        else if (fail_in || (prog_start && raise_bit))
            err <= 1'b1;
    end
endmodule

// File: rtl/pesr_top.sv
module pesr_top
    import pesr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned ABORT_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            mode,
    input  logic [7:0]            prog_data,
    input  logic [7:0]            cell_old,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_stb,
    input  logic [NUM_BLOCKS-1:0] erase_sel,
    input  logic [NUM_BLOCKS-1:0] prot_sel,
    input  logic                  fail_in,
    input  logic                  rd_reset,
    input  logic                  erase_window,
    input  logic [7:0]            array_data,
    output logic [7:0]            rd_data
);
    localparam int unsigned CNT_W  = $clog2(ABORT_CYC + 1);
    localparam int unsigned N_TOG  = 2;
    localparam int unsigned T_BUSY = 0;
    localparam int unsigned T_BLK  = 1;

    pe_mode_e   mode_c, mode_q;
    done_e      done_q;
    logic [7:0] pbyte_q;
    logic       prog_now, prog_start;
    logic       erase_run, erase_run_q;
    logic       all_prot, abort_busy, aborted_q;
    logic [CNT_W-1:0] abort_cnt;
    logic       in_sel, err_q;
    logic [N_TOG-1:0] tog_cond, tog_q;

    assign mode_c     = pe_mode_e'(mode);
    assign prog_now   = is_prog(mode_c);
    assign prog_start = prog_now && !is_prog(mode_q);
    assign erase_run  = (mode_c == MODE_ERASE) && !erase_window;
    assign all_prot   = (|erase_sel) && ((erase_sel & ~prot_sel) == '0);
    assign abort_busy = (abort_cnt != '0);

    pesr_block_map #(.ADDR_W(ADDR_W)) i_map (
        .addr   (rd_addr),
        .sel    (erase_sel),
        .in_sel (in_sel)
    );

    pesr_err_track i_err (
        .clk        (clk),
        .rst        (rst),
        .clr        (rd_reset),
        .fail_in    (fail_in),
        .prog_start (prog_start),
        .new_byte   (prog_data),
        .old_byte   (cell_old),
        .err        (err_q)
    );

    assign tog_cond[T_BUSY] = prog_now || (mode_c == MODE_ERASE);
    assign tog_cond[T_BLK]  = ((mode_c == MODE_ERASE) || (mode_c == MODE_SUSP))
                              && in_sel && !abort_busy;

    for (genvar t = 0; t < N_TOG; t++) begin : g_tog
        pesr_toggle i_tog (
            .clk  (clk),
            .rst  (rst),
            .stb  (rd_stb),
            .cond (tog_cond[t]),
            .q    (tog_q[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_IDLE;
            erase_run_q <= 1'b0;
            pbyte_q     <= '0;
            abort_cnt   <= '0;
            aborted_q   <= 1'b0;
            done_q      <= DONE_NONE;
        end else begin
            mode_q      <= mode_c;
            erase_run_q <= erase_run;
            if (prog_now) pbyte_q <= prog_data;

            if (mode_c != MODE_ERASE) begin
                abort_cnt <= '0;
                aborted_q <= 1'b0;
            end else if (abort_busy) begin
                abort_cnt <= abort_cnt - 1'b1;
                if (abort_cnt == CNT_W'(1)) aborted_q <= 1'b1;
            end else if (erase_run && !erase_run_q && all_prot && !aborted_q) begin
                abort_cnt <= CNT_W'(ABORT_CYC);
            end

            if (rd_reset || mode_c != MODE_IDLE)
                done_q <= DONE_NONE;
            else if (mode_q == MODE_PROG)
                done_q <= DONE_PROG;
            else if (mode_q == MODE_ERASE && !aborted_q)
                done_q <= DONE_ERASE;
        end
    end

    status_t st;
    logic    use_array;

    always_comb begin
        st        = '0;
        st.err    = err_q;
        use_array = 1'b0;
        unique case (mode_c)
            MODE_PROG, MODE_SUSP_PROG: begin
                st.poll     = ~prog_data[7];
                st.busy_tog = tog_q[T_BUSY];
                st.blk_tog  = 1'b1;
            end
            MODE_ERASE: begin
                if (aborted_q) begin
                    use_array = 1'b1;
                end else begin
                    st.poll     = 1'b0;
                    st.busy_tog = tog_q[T_BUSY];
                    st.timer    = ~erase_window;
                    st.blk_tog  = (in_sel && !abort_busy) ? tog_q[T_BLK] : 1'b1;
                end
            end
            MODE_SUSP: begin
                if (in_sel) begin
                    st.poll     = 1'b1;
                    st.busy_tog = 1'b1;
                    st.timer    = 1'b1;
                    st.blk_tog  = tog_q[T_BLK];
                end else begin
                    use_array = 1'b1;
                end
            end
            MODE_IDLE: begin
                unique case (done_q)
                    DONE_PROG: begin
                        st.poll     = pbyte_q[7];
                        st.busy_tog = tog_q[T_BUSY];
                        st.blk_tog  = 1'b1;
                    end
                    DONE_ERASE: begin
                        st.poll     = 1'b1;
                        st.busy_tog = tog_q[T_BUSY];
                        st.timer    = 1'b1;
                        st.blk_tog  = 1'b1;
                    end
                    default: use_array = 1'b1;
                endcase
            end
            default: use_array = 1'b1;
        endcase
    end

    assign rd_data = use_array ? array_data : st;
endmodule

// File: rtl/pesr_checker.sv
module pesr_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic [7:0] prog_data,
    input logic       rd_stb,
    input logic       erase_window,
    input logic       rd_reset,
    input logic [7:0] rd_data,
    input logic       err_q,
    input logic       abort_busy
);
    a_r1_prog_poll_inverted: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1) |-> (rd_data[7] == !prog_data[7]));

    a_r3_busy_toggles: assert property (@(posedge clk) disable iff (rst)
        ((mode == 3'd1) && $past(mode == 3'd1) && $past(rd_stb))
        |-> (rd_data[6] != $past(rd_data[6])));

    a_r5_prog_blk_bit_high: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1) |-> rd_data[2]);

    a_r8_window_open_timer_low: assert property (@(posedge clk) disable iff (rst)
        ((mode == 3'd2) && erase_window) |-> (!rd_data[3] && !rd_data[7]));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1) |-> (rd_data[1:0] == 2'b00 && !rd_data[4]));

    a_r7_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_q && !rd_reset) |=> err_q);

    a_r10_abort_poll_low: assert property (@(posedge clk) disable iff (rst)
        (abort_busy && mode == 3'd2) |-> !rd_data[7]);
endmodule

bind pesr_top pesr_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .prog_data    (prog_data),
    .rd_stb       (rd_stb),
    .erase_window (erase_window),
    .rd_reset     (rd_reset),
    .rd_data      (rd_data),
    .err_q        (err_q),
    .abort_busy   (abort_busy)
);

// File: tb/test_pesr_top.sv
module test_pesr_top;
    localparam int ADDR_W    = 18;
    localparam int ABORT_CYC = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode;
    logic [7:0]  prog_data, cell_old, array_data;
    logic [ADDR_W-1:0] rd_addr;
    logic        rd_stb, fail_in, rd_reset, erase_window;
    logic [6:0]  erase_sel, prot_sel;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pesr_top #(.ADDR_W(ADDR_W), .ABORT_CYC(ABORT_CYC)) i_pesr_top (
        .clk(clk), .rst(rst), .mode(mode), .prog_data(prog_data), .cell_old(cell_old),
        .rd_addr(rd_addr), .rd_stb(rd_stb), .erase_sel(erase_sel), .prot_sel(prot_sel),
        .fail_in(fail_in), .rd_reset(rd_reset), .erase_window(erase_window),
        .array_data(array_data), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(output logic [7:0] v);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic do_reset_cmd();
        mode = 3'd0;
        tick(); tick();
        rd_reset = 1'b1;
        tick();
        rd_reset = 1'b0;
        tick();
    endtask

    function automatic logic [ADDR_W-1:0] addr_of(input int blk);
        logic [4:0] top;
        case (blk)
            0: top = 5'h00; 1: top = 5'h08; 2: top = 5'h10; 3: top = 5'h18;
            4: top = 5'h1C; 5: top = 5'h1D; default: top = 5'h1E;
        endcase
        return {top, 13'(blk * 37 + 5)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v1, v2, v3, v4;
        rst = 1'b1; mode = 3'd0; prog_data = 8'h00; cell_old = 8'hFF;
        array_data = 8'h5A; rd_addr = '0; rd_stb = 1'b0; fail_in = 1'b0;
        rd_reset = 1'b0; erase_window = 1'b0; erase_sel = '0; prot_sel = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(rd_data == 8'h5A, "R11 reset passthrough", rd_data, 8'h5A);

        // program sweep over every byte value
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dd, e;
            dd = 8'(d);
            array_data = ~dd;
            prog_data = dd; cell_old = 8'hFF; mode = 3'd1;
            tick(); tick();
            rd(v1); rd(v2);
            e = {~dd[7], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00};
            chk((v1 & 8'hBF) == e, "R1 R5 R8 program status", v1 & 8'hBF, e);
            chk((v1 & 8'h13) == 8'h00, "R9 reserved zero", v1, 8'h00);
            chk(v2[6] != v1[6], "R3 busy toggle in program", v2, {1'b0, ~v1[6], 6'b0});
            mode = 3'd0;
            tick(); tick();
            rd(v3); rd(v4);
            e = {dd[7], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00};
            chk((v3 & 8'hBF) == e, "R1 R5 program done", v3 & 8'hBF, e);
            chk(v3[6] == v2[6] && v4[6] == v3[6], "R3 busy constant after done", v4, v2);
            do_reset_cmd();
            chk(rd_data == ~dd, "R11 passthrough after rd_reset", rd_data, ~dd);
        end

        // program during erase suspend
        prog_data = 8'h80; cell_old = 8'hFF; mode = 3'd4;
        tick(); tick();
        rd(v1); rd(v2);
        chk(v1[7] == 1'b0 && v1[2] == 1'b1, "R1 R5 suspend-program", v1, 8'h04);
        chk(v2[6] != v1[6], "R3 toggle in suspend-program", v2, v1 ^ 8'h40);
        do_reset_cmd();

        // error from writing 1 over 0
        prog_data = 8'h10; cell_old = 8'h0F; mode = 3'd1;
        tick(); tick();
        rd(v1);
        chk(v1[5] == 1'b1, "R7 error on 1 over 0", v1, v1 | 8'h20);
        mode = 3'd0; tick(); tick();
        rd(v1);
        chk(v1[5] == 1'b1, "R7 error sticky after done", v1, v1 | 8'h20);
        do_reset_cmd();
        prog_data = 8'h01; cell_old = 8'hFF; mode = 3'd1;
        tick(); tick();
        rd(v1);
        chk(v1[5] == 1'b0, "R7 error cleared by rd_reset", v1, v1 & 8'hDF);
        do_reset_cmd();

        // error from failure pulse during erase
        erase_sel = 7'h01; prot_sel = '0; erase_window = 1'b0; mode = 3'd2;
        tick(); tick();
        fail_in = 1'b1; tick(); fail_in = 1'b0; tick();
        rd(v1);
        chk(v1[5] == 1'b1, "R7 error on fail pulse", v1, v1 | 8'h20);
        do_reset_cmd();

        // erase sweep: every nonempty selection, every block
        for (int s = 1; s < 128; s++) begin
            erase_sel = 7'(s); prot_sel = '0; array_data = 8'h33;
            erase_window = 1'b1; mode = 3'd2;
            tick(); tick();
            rd(v1);
            chk(v1[3] == 1'b0 && v1[7] == 1'b0, "R8 R2 window open", v1, v1 & 8'h77);
            erase_window = 1'b0;
            tick(); tick();
            for (int b = 0; b < 7; b++) begin
                rd_addr = addr_of(b);
                tick();
                rd(v1); rd(v2);
                chk(v1[7] == 1'b0 && v1[3] == 1'b1 && (v1 & 8'h13) == 0,
                    "R2 R8 R9 erase status", v1, {1'b0, v1[6:4], 1'b1, v1[2], 2'b00});
                chk(v2[6] != v1[6], "R3 busy toggle in erase", v2, v1 ^ 8'h40);
                if (s[b])
                    chk(v2[2] != v1[2], "R4 block bit toggles in selected block", v2, v1 ^ 8'h04);
                else
                    chk(v1[2] && v2[2], "R4 block bit high outside selection", v2, v2 | 8'h04);
            end
            mode = 3'd0;
            tick(); tick();
            rd(v1); rd(v2);
            chk((v1 & 8'hBF) == 8'h8C, "R2 R5 erase done", v1 & 8'hBF, 8'h8C);
            chk(v2[6] == v1[6], "R3 busy constant after erase", v2, v1);
            do_reset_cmd();
        end

        // erase suspend
        erase_sel = 7'b0000101; prot_sel = '0; array_data = 8'h6C;
        erase_window = 1'b0; mode = 3'd2;
        tick(); tick();
        mode = 3'd3;
        tick();
        for (int b = 0; b < 7; b++) begin
            rd_addr = addr_of(b);
            tick();
            rd(v1); rd(v2);
            if (b == 0 || b == 2) begin
                chk(v1[7] && v1[6] && v2[7] && v2[6], "R6 suspended block poll and busy high", v1, v1 | 8'hC0);
                chk(v2[2] != v1[2], "R6 block bit toggles in suspended block", v2, v1 ^ 8'h04);
            end else begin
                chk(v1 == 8'h6C && v2 == 8'h6C, "R6 other block passthrough", v1, 8'h6C);
            end
        end
        do_reset_cmd();

        // all selected blocks protected
        erase_sel = 7'b0011000; prot_sel = 7'h7F; array_data = 8'hA5;
        rd_addr = addr_of(3);
        erase_window = 1'b1; mode = 3'd2;
        tick(); tick();
        erase_window = 1'b0;
        tick();
        rd(v1); rd(v2);
        chk(v1[7] == 1'b0 && v2[7] == 1'b0, "R10 abort poll low", v1, v1 & 8'h7F);
        chk(v2[6] != v1[6], "R10 abort busy toggles", v2, v1 ^ 8'h40);
        repeat (ABORT_CYC + 4) tick();
        chk(rd_data == 8'hA5, "R10 array after abort", rd_data, 8'hA5);
        mode = 3'd0;
        tick(); tick();
        chk(rd_data == 8'hA5, "R10 R11 idle after abort", rd_data, 8'hA5);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule